// File: doc/BRIEF.md
# Byte-Parity Checked Word Memory

This block is a synchronous single-port word memory that keeps one even parity bit beside every byte of each stored word. Any write may update one byte, a half word or the full 32-bit word, chosen by a per-lane write strobe. Each written lane gets a freshly computed parity bit. Every read returns the full word and checks all four lanes against their stored parity bits. The read data and the check result appear together, one clock after the request, with no wait states.

A test input makes writes store the complement of the correct parity bit. Software can then force a parity fault at a chosen address and exercise the detection path end to end. Any detected mismatch sets a sticky error flag. Software clears that flag with a write-one-to-clear pulse. When the reset-request option is enabled, the same mismatch also pulses a request for a system reset. The storage is an inferred register array and reset does not initialise it.

Top module: `par_sram_wrap`

## Requirements
- R1: A read request (`req_valid`=1, `req_write`=0) returns the full stored word on `rsp_rdata`, with `rsp_valid`=1, in the cycle after the request is sampled.
- R2: Write strobe bit i selects byte lane i, which is bits 8i+7..8i. A single-byte write (one strobe bit set) changes only that lane, and the other three bytes read back unchanged.
- R3: Half-word writes (strobe 4'b0011 or 4'b1100) and full-word writes (4'b1111) update exactly the selected lanes.
- R4: A location written with `par_invert`=0 reads back with `rsp_perr`=0 and leaves `err_flag` unchanged.
- R5: A lane written while `par_invert`=1 stores an odd-parity bit. A later read of that word gives `rsp_perr`=1, and `err_flag`=1 in the same cycle as the data.
- R6: Parity bits are updated only for strobed lanes. Rewriting one lane of a faulted word without inversion still reports an error while other lanes remain inverted, and a full clean rewrite removes it.
- R7: `err_flag` stays set until an `err_clr` pulse arrives with no new error. If a read error arrives in the same cycle as `err_clr`, the flag stays set.
- R8: `rst_req` pulses high for one cycle with an erroring read response only when `rst_req_en`=1. With `rst_req_en`=0 only the flag is raised.
- R9: During and directly after reset, `rsp_valid`, `rsp_perr`, `err_flag` and `rst_req` are 0.
- R10: A write request produces no response (`rsp_valid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_strb | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data |
| par_invert | input | 1 | Store complemented parity on writes (test) |
| rst_req_en | input | 1 | Allow parity errors to request reset |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_perr | output | 1 | Parity mismatch on this read |
| err_flag | output | 1 | Sticky parity error flag |
| rst_req | output | 1 | System reset request pulse |

## Verification
On every cycle, the assertions check several properties. Responses follow only read requests. A faulty read always shows in the flag and never outside a response. The flag persists until a clean clear. A reset request never appears without the flag. Data integrity across partial writes depends on the memory contents, so only the bench scenarios can show it. The same holds for the effect of inverted parity on later reads and for the partial repair of a faulted word. These scenarios compare each response against a scoreboard of expected words.

// File: rtl/sram_par_pkg.sv
package sram_par_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t      data;
        lane_mask_t par;
    } stored_word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // even parity bit per byte lane: makes byte plus bit carry an even count of ones
    function automatic lane_mask_t lane_parity(input word_t w);
        lane_mask_t p;
        for (int i = 0; i < LANES; i++) begin
            p[i] = ^w[i*BYTE_W +: BYTE_W];
        end
        return p;
    endfunction
endpackage

// File: rtl/par_encode.sv
module par_encode
    import sram_par_pkg::*;
(
    input  word_t        wdata,
    input  logic         invert,
    output stored_word_t enc
);
    lane_mask_t good;

    always_comb begin
        good     = lane_parity(wdata);
        enc.data = wdata;
        enc.par  = invert ? ~good : good;
    end
endmodule

// File: rtl/par_array.sv
module par_array
    import sram_par_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         we,
    input  logic         re,
    input  logic [AW-1:0] addr,
    input  lane_mask_t   lane_we,
    input  stored_word_t wword,
    output stored_word_t rword
);
    localparam int SLICE_W = BYTE_W + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SLICE_W-1:0] mem [DEPTH];
        logic [SLICE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we && lane_we[g]) begin
                mem[addr] <= {wword.par[g], wword.data[g*BYTE_W +: BYTE_W]};
            end
            if (re) begin
                rd_q <= mem[addr];
            end
        end

        assign rword.data[g*BYTE_W +: BYTE_W] = rd_q[BYTE_W-1:0];
        assign rword.par[g]                   = rd_q[BYTE_W];
    end
endmodule

// File: rtl/par_check.sv
module par_check
    import sram_par_pkg::*;
(
    input  stored_word_t rword,
    input  logic         rvalid,
    output lane_mask_t   lane_bad,
    output logic         any_bad
);
    always_comb begin
        lane_bad = rvalid ? (lane_parity(rword.data) ^ rword.par) : '0;
        any_bad  = |lane_bad;
    end
endmodule

// File: rtl/par_err_ctrl.sv
module par_err_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic rd_err,
    input  logic err_clr,
    input  logic rst_req_en,
    output logic err_flag,
    output logic rst_req
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (rd_err) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign err_flag = err_q | rd_err;
    assign rst_req  = rd_err & rst_req_en;

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !rd_err) |=> !err_q);

    // R8
    rst_req_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> err_flag);
endmodule

// File: rtl/par_sram_wrap.sv
module par_sram_wrap
    import sram_par_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [LANES-1:0]  req_strb,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              par_invert,
    input  logic              rst_req_en,
    input  logic              err_clr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_perr,
    output logic              err_flag,
    output logic              rst_req
);
    op_e          op;
    stored_word_t wr_word;
    stored_word_t rd_word;
    lane_mask_t   lane_bad;
    logic         any_bad;
    logic         rsp_q;

    always_comb begin
        if (!req_valid)     op = OP_IDLE;
        else if (req_write) op = OP_WRITE;
        else                op = OP_READ;
    end

    par_encode u_enc (
        .wdata  (req_wdata),
        .invert (par_invert),
        .enc    (wr_word)
    );

    par_array #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we      (op == OP_WRITE),
        .re      (op == OP_READ),
        .addr    (req_addr),
        .lane_we (req_strb),
        .wword   (wr_word),
        .rword   (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= 1'b0;
        else     rsp_q <= (op == OP_READ);
    end

    par_check u_chk (
        .rword    (rd_word),
        .rvalid   (rsp_q),
        .lane_bad (lane_bad),
        .any_bad  (any_bad)
    );

    par_err_ctrl u_err (
        .clk        (clk),
        .rst        (rst),
        .rd_err     (any_bad),
        .err_clr    (err_clr),
        .rst_req_en (rst_req_en),
        .err_flag   (err_flag),
        .rst_req    (rst_req)
    );

    assign rsp_valid = rsp_q;
    assign rsp_rdata = rd_word.data;
    assign rsp_perr  = any_bad;

    // R1 R10
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R5
    perr_in_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_perr |-> (rsp_valid && err_flag));

    // R9
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !err_flag && !rst_req));

    // R5
    lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_bad != '0) |-> rsp_valid);
endmodule

// File: tb/par_sram_wrap_tb.sv
module par_sram_wrap_tb;
    localparam int CLK_NS = 20;
    localparam int DEPTH  = 64;
    localparam int AW     = $clog2(DEPTH);

    typedef struct {
        logic [31:0] data;
        logic        perr;
        logic        rreq;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_strb = '0;
    logic [31:0]   req_wdata = '0;
    logic          par_invert = 1'b0;
    logic          rst_req_en = 1'b0;
    logic          err_clr = 1'b0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_perr;
    logic          err_flag;
    logic          rst_req;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];
    exp_t mon_it;

    always #(CLK_NS/2) clk = ~clk;

    par_sram_wrap #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
        .par_invert(par_invert), .rst_req_en(rst_req_en), .err_clr(err_clr),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
        .err_flag(err_flag), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input logic [3:0] s, input logic [31:0] d, input logic inv);
        cyc();
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a);
        req_strb = s; req_wdata = d; par_invert = inv;
        cyc();
        req_valid = 1'b0; req_write = 1'b0; par_invert = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] d, input logic perr, input string tag);
        exp_t it;
        cyc();
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        it.data = d; it.perr = perr; it.rreq = perr & rst_req_en; it.tag = tag;
        exp_q.push_back(it);
        cyc();
        req_valid = 1'b0;
    endtask

    task automatic check_flag(input logic exp, input string tag);
        repeat (3) cyc();
        @(negedge clk);
        check(err_flag === exp, tag, 32'(err_flag), 32'(exp));
    endtask

    task automatic pulse_clr();
        cyc();
        err_clr = 1'b1;
        cyc();
        err_clr = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
                end else begin
                    mon_it = exp_q.pop_front();
                    check(rsp_rdata === mon_it.data, {mon_it.tag, " data"}, rsp_rdata, mon_it.data);
                    check(rsp_perr === mon_it.perr, {mon_it.tag, " perr"}, 32'(rsp_perr), 32'(mon_it.perr));
                    if (mon_it.perr)
                        check(err_flag === 1'b1, "R5 flag with data", 32'(err_flag), 32'h1);
                    check(rst_req === mon_it.rreq, "R8 rst_req", 32'(rst_req), 32'(mon_it.rreq));
                end
            end else if (rst_req) begin
                check(1'b0, "R8 rst_req without response", 32'h1, 32'h0);
            end
        end
    end

    initial begin
        #(CLK_NS * 150000);
        n_tests++; n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=0", exp_q.size());
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(rsp_valid === 1'b0, "R9 rsp_valid", 32'(rsp_valid), 32'h0);
        check(err_flag === 1'b0, "R9 err_flag", 32'(err_flag), 32'h0);
        check(rst_req === 1'b0, "R9 rst_req", 32'(rst_req), 32'h0);
        cyc();
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_perr === 1'b0, "R9 after release", 32'(rsp_valid), 32'h0);

        // R1 R4 R10 full words at several addresses
        wr(0, 4'b1111, 32'h1234_5678, 1'b0);
        wr(5, 4'b1111, 32'hDEAD_BEEF, 1'b0);
        wr(63, 4'b1111, 32'hA5A5_0F0F, 1'b0);
        rd(0, 32'h1234_5678, 1'b0, "R1 addr0");
        rd(5, 32'hDEAD_BEEF, 1'b0, "R1 addr5");
        rd(63, 32'hA5A5_0F0F, 1'b0, "R1 addr63");

        // R2 single-byte writes
        wr(5, 4'b0010, 32'h0000_7700, 1'b0);
        rd(5, 32'hDEAD_77EF, 1'b0, "R2 lane1");
        wr(5, 4'b1000, 32'h1100_0000, 1'b0);
        rd(5, 32'h11AD_77EF, 1'b0, "R2 lane3");

        // R3 half-word writes
        wr(63, 4'b1100, 32'hCAFE_FFFF, 1'b0);
        rd(63, 32'hCAFE_0F0F, 1'b0, "R3 upper half");
        wr(63, 4'b0011, 32'hFFFF_1234, 1'b0);
        rd(63, 32'hCAFE_1234, 1'b0, "R3 lower half");
        check_flag(1'b0, "R4 flag after clean reads");

        // R5 R8 forced error without reset request
        rst_req_en = 1'b0;
        wr(7, 4'b1111, 32'h0F0F_3C3C, 1'b1);
        rd(7, 32'h0F0F_3C3C, 1'b1, "R5 inverted word");
        check_flag(1'b1, "R7 flag held");
        pulse_clr();
        check_flag(1'b0, "R7 flag cleared");

        // R6 partial repair keeps error, full rewrite clears
        wr(7, 4'b0001, 32'h0000_0099, 1'b0);
        rd(7, 32'h0F0F_3C99, 1'b1, "R6 partial repair");
        pulse_clr();
        wr(7, 4'b1111, 32'h7654_3210, 1'b0);
        rd(7, 32'h7654_3210, 1'b0, "R6 full rewrite");
        check_flag(1'b0, "R6 flag after clean rewrite");
        wr(8, 4'b1111, 32'h0000_0000, 1'b0);
        wr(8, 4'b0100, 32'h0080_0000, 1'b1);
        rd(0, 32'h1234_5678, 1'b0, "R6 other address clean");

        // R8 reset request enabled
        rst_req_en = 1'b1;
        rd(8, 32'h0080_0000, 1'b1, "R8 single lane inverted");
        cyc();
        rst_req_en = 1'b0;

        // R7 set wins over simultaneous clear
        pulse_clr();
        check_flag(1'b0, "R7 clear before race");
        rd(8, 32'h0080_0000, 1'b1, "R7 race read");
        err_clr = 1'b1;
        cyc();
        err_clr = 1'b0;
        check_flag(1'b1, "R7 set beats clear");
        pulse_clr();
        check_flag(1'b0, "R7 final clear");

        repeat (4) cyc();
        check(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule